// File: doc/BRIEF.md
# Serial Peripheral Register Bank with Bit Aliases

This block is the software-visible register file of a serial peripheral. A simple bus carries a write enable, a byte address, write data and read data; reads are combinational and writes take effect at the clock edge. Three registers (control, status, control2) each sit in a group of four words. The first word is the register itself. The other three are write-only aliases that clear, set or invert the bits written as ones in a single write, so software never needs a read-modify-write sequence. Apart from the groups, the bank holds a data-buffer word and a 9-bit baud divider.

The serial core around the bank receives the control, control2 and divider values on output ports. It supplies its live status bits (levels, empty flags) and single-cycle error event pulses. The three error conditions are receive overrun, transmit underrun and frame error. Each one is latched into a sticky flag that only software can clear. A fault interrupt is raised while any latched flag has its enable bit set in control2.

Top module: `sci_alias_regs`

## Requirements
- R1: After reset, control, control2 and the baud divider read zero, all three sticky error flags are clear, and `fault_irq` is low.
- R2: For control (group at 0x00) and control2 (group at 0x40), a write to the group base replaces the register. A write to base+0x4 clears the bits set in the data, base+0x8 sets them, and base+0xC inverts them. The base address reads the current value, which also appears on `ctl_o` / `ctl2_o`.
- R3: Alias words read zero. This covers offsets +0x4, +0x8 and +0xC of the control, status and control2 groups, the words 0x24–0x2C and 0x34–0x3C, and every address from 0x50 up. Writes to the reserved words and unmapped addresses change no register.
- R4: A write to 0x30 keeps only bits 8:0 as the baud divider and ignores the upper bits. The register reads back zero-extended and drives `baud_o`.
- R5: Reading 0x10 returns the status word. Bit 6 is the receive-overrun flag, bit 8 the transmit-underrun flag and bit 12 the frame-error flag. Every other bit mirrors `stat_hw_i`. A one-cycle event pulse sets its flag, and the flag then stays set.
- R6: Writing ones to 0x14 clears the corresponding sticky flags; ones at other bit positions have no effect. Writes to 0x10, 0x18 and 0x1C leave the status word unchanged.
- R7: If an error event and a clear-alias write for the same flag occur in the same cycle, the flag ends up set.
- R8: `fault_irq` is high exactly when at least one latched flag has its enable set. Control2 bit 10 enables transmit underrun, bit 11 receive overrun and bit 12 frame error.
- R9: A write to 0x20 produces a one-cycle `tx_push` on the following cycle, with `tx_word` equal to the written data. A read of 0x20 returns `rx_word_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | 8 | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| stat_hw_i | input | 32 | Live status bits from the serial core |
| ev_rovr_i | input | 1 | Receive overrun event pulse |
| ev_tudr_i | input | 1 | Transmit underrun event pulse |
| ev_ferr_i | input | 1 | Frame error event pulse |
| rx_word_i | input | 32 | Word at the head of the receive path |
| tx_push | output | 1 | One-cycle strobe: a word was written to the buffer |
| tx_word | output | 32 | Word written to the buffer |
| ctl_o | output | 32 | Control register value |
| ctl2_o | output | 32 | Control2 register value |
| baud_o | output | 9 | Baud divider |
| fault_irq | output | 1 | Gated fault interrupt |

## Verification
A decoding fault in the alias path shows up on `ctl_o` or `ctl2_o` one cycle after the write. The effect is a wrong bit pattern or a change caused by a write to another address. A sticky flag that drops early, or never latches, is visible through a status read and on `fault_irq` in the cycle after the event or clear. The tests that matter most are the clear/event collision, and enable bits that gate the wrong flag. Each of these flips `fault_irq` only for a specific combination of flag and enable, so every pairing is driven on its own.

// File: rtl/sci_alias_regs.sv
module sci_alias_regs #(
  parameter int AW       = 8,
  parameter int DW       = 32,
  parameter int BAUD_W   = 9,
  parameter int BIT_ROVR = 6,
  parameter int BIT_TUDR = 8,
  parameter int BIT_FERR = 12,
  parameter int EN_TUDR  = 10,
  parameter int EN_ROVR  = 11,
  parameter int EN_FERR  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [DW-1:0]     stat_hw_i,
  input  logic              ev_rovr_i,
  input  logic              ev_tudr_i,
  input  logic              ev_ferr_i,
  input  logic [DW-1:0]     rx_word_i,
  output logic              tx_push,
  output logic [DW-1:0]     tx_word,
  output logic [DW-1:0]     ctl_o,
  output logic [DW-1:0]     ctl2_o,
  output logic [BAUD_W-1:0] baud_o,
  output logic              fault_irq
);
  localparam int GW = AW - 4;
  localparam logic [GW-1:0] G_CTL  = GW'(0);
  localparam logic [GW-1:0] G_STAT = GW'(1);
  localparam logic [GW-1:0] G_BUF  = GW'(2);
  localparam logic [GW-1:0] G_BAUD = GW'(3);
  localparam logic [GW-1:0] G_CTL2 = GW'(4);
  localparam logic [1:0] OP_WR  = 2'd0;
  localparam logic [1:0] OP_CLR = 2'd1;
  localparam logic [1:0] OP_SET = 2'd2;
  localparam logic [1:0] OP_INV = 2'd3;
  localparam logic [DW-1:0] STK_MASK =
    (DW'(1) << BIT_ROVR) | (DW'(1) << BIT_TUDR) | (DW'(1) << BIT_FERR);

  wire [GW-1:0] grp = bus_addr[AW-1:4];
  wire [1:0]    op  = bus_addr[3:2];

  logic [DW-1:0]     ctl_q, ctl2_q;
  logic [BAUD_W-1:0] baud_q;
  logic [2:0]        err_q;
  logic [DW-1:0]     stat_view;

  function automatic logic [DW-1:0] apply_op(input logic [DW-1:0] cur,
                                             input logic [DW-1:0] wd,
                                             input logic [1:0]    o);
    case (o)
      OP_WR:   apply_op = wd;
      OP_CLR:  apply_op = cur & ~wd;
      OP_SET:  apply_op = cur | wd;
      default: apply_op = cur ^ wd;
    endcase
  endfunction

  wire wr_ctl  = bus_we && grp == G_CTL;
  wire wr_ctl2 = bus_we && grp == G_CTL2;
  wire wr_baud = bus_we && grp == G_BAUD && op == OP_WR;
  wire wr_buf  = bus_we && grp == G_BUF  && op == OP_WR;
  wire wr_sclr = bus_we && grp == G_STAT && op == OP_CLR;

  wire [2:0] clr_bits = wr_sclr ? {bus_wdata[BIT_FERR], bus_wdata[BIT_TUDR], bus_wdata[BIT_ROVR]} : 3'b000;
  wire [2:0] ev_bits  = {ev_ferr_i, ev_tudr_i, ev_rovr_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      ctl2_q  <= '0;
      baud_q  <= '0;
      err_q   <= '0;
      tx_push <= 1'b0;
      tx_word <= '0;
    end else begin
      if (wr_ctl)  ctl_q  <= apply_op(ctl_q, bus_wdata, op);
      if (wr_ctl2) ctl2_q <= apply_op(ctl2_q, bus_wdata, op);
      if (wr_baud) baud_q <= bus_wdata[BAUD_W-1:0];
      err_q   <= (err_q & ~clr_bits) | ev_bits;
      tx_push <= wr_buf;
      if (wr_buf) tx_word <= bus_wdata;
    end
  end

  always_comb begin
    stat_view = stat_hw_i & ~STK_MASK;
    stat_view[BIT_ROVR] = err_q[0];
    stat_view[BIT_TUDR] = err_q[1];
    stat_view[BIT_FERR] = err_q[2];
  end

  always_comb begin
    bus_rdata = '0;
    if (op == OP_WR) begin
      case (grp)
        G_CTL:   bus_rdata = ctl_q;
        G_STAT:  bus_rdata = stat_view;
        G_BUF:   bus_rdata = rx_word_i;
        G_BAUD:  bus_rdata = DW'(baud_q);
        G_CTL2:  bus_rdata = ctl2_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign ctl_o  = ctl_q;
  assign ctl2_o = ctl2_q;
  assign baud_o = baud_q;
  assign fault_irq = (err_q[0] & ctl2_q[EN_ROVR]) |
                     (err_q[1] & ctl2_q[EN_TUDR]) |
                     (err_q[2] & ctl2_q[EN_FERR]);

  a_r2_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctl |=> $stable(ctl_o));
  a_r4_baud_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_baud |=> $stable(baud_o));
  a_r5_rovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q[0] && !(wr_sclr && bus_wdata[BIT_ROVR])) |=> err_q[0]);
  a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rovr_i |=> stat_view[BIT_ROVR]);
  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    fault_irq |-> (err_q != 3'b000));
  a_r9_push_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_buf |=> tx_push && tx_word == $past(bus_wdata));
endmodule

// File: tb/tb_sci_alias_regs.sv
module tb_sci_alias_regs;
  localparam int CLK_NS = 10;

  logic        clk = 0, rst_n = 0;
  logic        bus_we = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [31:0] stat_hw_i = 0, rx_word_i = 0;
  logic        ev_rovr_i = 0, ev_tudr_i = 0, ev_ferr_i = 0;
  logic        tx_push, fault_irq;
  logic [31:0] tx_word, ctl_o, ctl2_o;
  logic [8:0]  baud_o;
  int checks = 0, fails = 0;

  always #(CLK_NS/2) clk = ~clk;

  sci_alias_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stat_hw_i(stat_hw_i),
    .ev_rovr_i(ev_rovr_i), .ev_tudr_i(ev_tudr_i), .ev_ferr_i(ev_ferr_i),
    .rx_word_i(rx_word_i), .tx_push(tx_push), .tx_word(tx_word),
    .ctl_o(ctl_o), .ctl2_o(ctl2_o), .baud_o(baud_o), .fault_irq(fault_irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0; bus_wdata = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    ev_rovr_i = (which == 0); ev_tudr_i = (which == 1); ev_ferr_i = (which == 2);
    @(negedge clk);
    ev_rovr_i = 0; ev_tudr_i = 0; ev_ferr_i = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h00, d); chk("R1 ctl", d, 0);
    rd(8'h40, d); chk("R1 ctl2", d, 0);
    rd(8'h30, d); chk("R1 baud", d, 0);
    rd(8'h10, d); chk("R1 status", d, 0);
    chk("R1 irq", {31'b0, fault_irq}, 0);
  endtask

  task automatic t_ctl_alias;
    logic [31:0] d;
    wr(8'h00, 32'h0000_F0F0); chk("R2 ctl write", ctl_o, 32'h0000_F0F0);
    wr(8'h04, 32'h0000_00F0); chk("R2 ctl clear", ctl_o, 32'h0000_F000);
    wr(8'h08, 32'h8000_000F); chk("R2 ctl set", ctl_o, 32'h8000_F00F);
    wr(8'h0C, 32'hFFFF_0000); rd(8'h00, d); chk("R2 ctl invert", d, 32'h7FFF_F00F);
    wr(8'h40, 32'h1234_5678); chk("R2 ctl2 write", ctl2_o, 32'h1234_5678);
    wr(8'h44, 32'h0000_0078); wr(8'h48, 32'h8000_0000); wr(8'h4C, 32'h0000_0F00);
    rd(8'h40, d); chk("R2 ctl2 aliases", d, 32'h9234_5900);
    chk("R2 ctl untouched", ctl_o, 32'h7FFF_F00F);
  endtask

  task automatic t_zero_reads;
    logic [31:0] d;
    rd(8'h04, d); chk("R3 ctl clr alias", d, 0);
    rd(8'h18, d); chk("R3 stat set alias", d, 0);
    rd(8'h4C, d); chk("R3 ctl2 inv alias", d, 0);
    rd(8'h28, d); chk("R3 reserved buf", d, 0);
    rd(8'h3C, d); chk("R3 reserved baud", d, 0);
    rd(8'h50, d); chk("R3 unmapped", d, 0);
    wr(8'h24, 32'hFFFF_FFFF); wr(8'h34, 32'hFFFF_FFFF); wr(8'h54, 32'hFFFF_FFFF); wr(8'hF0, 32'hFFFF_FFFF);
    chk("R3 ctl after junk", ctl_o, 32'h7FFF_F00F);
    chk("R3 ctl2 after junk", ctl2_o, 32'h9234_5900);
    chk("R3 baud after junk", {23'b0, baud_o}, 0);
    chk("R3 no push", {31'b0, tx_push}, 0);
  endtask

  task automatic t_baud;
    logic [31:0] d;
    wr(8'h30, 32'hFFFF_FE5A); rd(8'h30, d);
    chk("R4 baud masked", d, 32'h0000_005A);
    wr(8'h30, 32'h0000_01FF); chk("R4 baud port", {23'b0, baud_o}, 32'h1FF);
  endtask

  task automatic t_sticky;
    logic [31:0] d;
    stat_hw_i = 32'hFFFF_FFFF; rd(8'h10, d);
    chk("R5 hw mirror, flags clear", d, 32'hFFFF_EEBF);
    stat_hw_i = 32'h0A00_0020;
    pulse(0); rd(8'h10, d); chk("R5 rovr latched", d, 32'h0A00_0060);
    repeat (3) @(negedge clk);
    rd(8'h10, d); chk("R5 rovr holds", d, 32'h0A00_0060);
    pulse(1); pulse(2); rd(8'h10, d); chk("R5 all flags", d, 32'h0A00_1160);
    wr(8'h10, 32'h0); wr(8'h18, 32'hFFFF_FFFF); wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h10, d); chk("R6 base/set/inv no effect", d, 32'h0A00_1160);
    wr(8'h14, 32'hFFFF_EEBF); rd(8'h10, d); chk("R6 non-flag bits", d, 32'h0A00_1160);
    wr(8'h14, 32'h0000_0040); rd(8'h10, d); chk("R6 clear rovr", d, 32'h0A00_1120);
    wr(8'h14, 32'h0000_1100); rd(8'h10, d); chk("R6 clear rest", d, 32'h0A00_0020);
    stat_hw_i = 0;
  endtask

  task automatic t_race;
    logic [31:0] d;
    pulse(0);
    @(negedge clk); bus_we = 1; bus_addr = 8'h14; bus_wdata = 32'h40; ev_rovr_i = 1;
    @(negedge clk); bus_we = 0; bus_wdata = 0; ev_rovr_i = 0;
    rd(8'h10, d); chk("R7 event beats clear", d, 32'h40);
    wr(8'h14, 32'h40); rd(8'h10, d); chk("R7 later clear", d, 0);
  endtask

  task automatic t_fault;
    wr(8'h40, 32'h0);
    pulse(0); chk("R8 rovr disabled", {31'b0, fault_irq}, 0);
    wr(8'h48, 32'h0000_0800); chk("R8 rovr enabled", {31'b0, fault_irq}, 1);
    wr(8'h44, 32'h0000_0800); chk("R8 rovr masked", {31'b0, fault_irq}, 0);
    wr(8'h14, 32'h40);
    wr(8'h48, 32'h0000_1800); pulse(1); chk("R8 tudr wrong enables", {31'b0, fault_irq}, 0);
    wr(8'h4C, 32'h0000_0400); chk("R8 tudr enabled", {31'b0, fault_irq}, 1);
    wr(8'h14, 32'h100); chk("R8 tudr cleared", {31'b0, fault_irq}, 0);
    wr(8'h40, 32'h0000_1000); pulse(2); chk("R8 ferr enabled", {31'b0, fault_irq}, 1);
    wr(8'h14, 32'h1000); chk("R8 ferr cleared", {31'b0, fault_irq}, 0);
  endtask

  task automatic t_buffer;
    logic [31:0] d;
    rx_word_i = 32'hCAFE_F00D; rd(8'h20, d); chk("R9 rx read", d, 32'hCAFE_F00D);
    wr(8'h20, 32'hA5A5_0001);
    chk("R9 push", {31'b0, tx_push}, 1); chk("R9 word", tx_word, 32'hA5A5_0001);
    @(negedge clk); chk("R9 push one cycle", {31'b0, tx_push}, 0);
  endtask

  initial begin
    #(CLK_NS * 50000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_ctl_alias;
    t_zero_reads;
    t_baud;
    t_sticky;
    t_race;
    t_fault;
    t_buffer;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule